// File: doc/BRIEF.md
# TDM Frame Timing and Control-Stream Generator

This block derives all frame timing of a time-division multiplexed serial switch from a single bit-rate clock running at twice the bit rate and an active-low frame pulse. A free-running cycle counter covers one frame of 32 channels of 8 bits, two clocks per bit cell (512 clocks). It presents the current channel, the bit index (most significant bit first) and the half-cell phase to the receive and transmit paths, together with a one-cycle frame-start strobe.

It also builds a serial control stream that carries, once per frame, one per-slot control bit for each of the 8 streams and 32 channels (256 bits). The bits are read from the connection-high store of the switch core through a one-bit read port that the block addresses. Each bit goes out one channel ahead of the data channel it belongs to. Within one channel time the eight bit cells carry streams 0 through 7 in that order, so external logic has a full channel time to act on a bit. The read address runs one clock ahead of each bit cell, and the fetched bit is registered at the cell boundary.

A low frame pulse seen at a clock edge puts the counter at channel 0, bit 7, phase 0 on that edge, wherever the counter was. With no pulse the counter wraps by itself.

Top module: `tdm_frame_timing`

## Requirements
- R1: After reset the outputs show channel 0, bit index 7, phase 0, frame_start high and ctl_o low.
- R2: Without a frame pulse the phase alternates 0,1 on each clock. The bit index steps down 7..0, one step per two clocks. The channel rises by one after bit 0 phase 1.
- R3: Without a frame pulse, channel 31 bit 0 phase 1 is followed by channel 0 bit 7 phase 0, giving a 512-clock frame.
- R4: If fp_n is low at a rising clock edge, the next cycle shows channel 0, bit 7, phase 0, whatever the counter position was before.
- R5: frame_start is high exactly in the cycles showing channel 0, bit 7, phase 0.
- R6: In every cycle, ctl_rd_stream and ctl_rd_chan address the bit cell the counter enters on the next edge. That next position depends on fp_n. For a cell at slot s (s = 7 − bit index) of channel c, ctl_rd_stream is s and ctl_rd_chan is (c+1) mod 32.
- R7: Throughout the bit cell at slot s of channel c, ctl_o holds the value ctl_rd_bit had when that stream/channel pair was addressed at the edge starting the cell. This is the bit for stream s, channel (c+1) mod 32.
- R8: During channel 31, ctl_o carries the control bits of channel 0, streams 0..7.
- R9: After a frame pulse, the first bit cell carries the control bit of stream 0, channel 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock, two cycles per bit cell |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_n | input | 1 | Active-low frame pulse, sampled on rising edges |
| ctl_rd_bit | input | 1 | Control bit returned by the connection-high store for the current address |
| chan_idx | output | 5 | Current channel, 0..31 |
| bit_idx | output | 3 | Current bit within the channel, 7 first |
| bit_phase | output | 1 | Clock phase within the bit cell |
| frame_start | output | 1 | High in the first clock of a frame |
| ctl_rd_stream | output | 3 | Stream part of the control read address |
| ctl_rd_chan | output | 5 | Channel part of the control read address |
| ctl_o | output | 1 | Serial control stream |

## Verification
The bench sends frame pulses at random points in the frame. These include back-to-back pulses and pulses on the last clock of a frame. A counter that resynchronised one clock late, or ignored a pulse that arrived while it was already near the wrap, would show a wrong channel or bit straight away. Long runs with no pulse check the self-wrap, where an off-by-one frame length would drift. The control stream is compared with a random connection-high image that keeps changing. A design that dropped the one-channel advance, skipped the channel-31-to-0 wrap, ordered the streams in reverse, or fetched the address of the current cell instead of the next one would put a wrong bit in some cell.

// File: rtl/tdm_timing_pkg.sv
package tdm_timing_pkg;
  // Default frame geometry shared by the block and its checker.
  localparam int unsigned DEF_CHANNELS    = 32;
  localparam int unsigned DEF_BITS        = 8;   // bits per channel == streams interleaved per channel
  localparam int unsigned DEF_CLK_PER_BIT = 2;

  typedef enum logic [1:0] {
    TAG_RUN   = 2'd0,
    TAG_WRAP  = 2'd1,
    TAG_SYNC  = 2'd2
  } cnt_event_e;
endpackage

// File: rtl/tfg_frame_counter.sv
module tfg_frame_counter #(
  parameter int unsigned FRAME_CLKS = 512,
  localparam int unsigned CW = $clog2(FRAME_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fp_n,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output tdm_timing_pkg::cnt_event_e evt
);
  import tdm_timing_pkg::*;

  localparam logic [CW-1:0] LAST = CW'(FRAME_CLKS - 1);

  logic cnt_en;
  assign cnt_en = 1'b1;

  // next-state logic
  always_comb begin
    if (!fp_n) begin
      cnt_nxt = '0;
      evt     = TAG_SYNC;
    end else if (cnt_q == LAST) begin
      cnt_nxt = '0;
      evt     = TAG_WRAP;
    end else begin
      cnt_nxt = cnt_q + CW'(1);
      evt     = TAG_RUN;
    end
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/tfg_pos_decode.sv
module tfg_pos_decode #(
  parameter int unsigned CHANNELS    = 32,
  parameter int unsigned BITS        = 8,
  parameter int unsigned CLK_PER_BIT = 2,
  localparam int unsigned PHW = $clog2(CLK_PER_BIT),
  localparam int unsigned SLW = $clog2(BITS),
  localparam int unsigned CHW = $clog2(CHANNELS),
  localparam int unsigned CW  = PHW + SLW + CHW
) (
  input  logic [CW-1:0]  cnt,
  output logic [CHW-1:0] chan,
  output logic [SLW-1:0] slot,
  output logic [PHW-1:0] phase
);
  // cycle count = {channel, slot within channel, clock phase in bit cell}
  assign phase = cnt[PHW-1:0];
  assign slot  = cnt[PHW+SLW-1:PHW];
  assign chan  = cnt[CW-1:PHW+SLW];
endmodule

// File: rtl/tfg_ctl_gen.sv
module tfg_ctl_gen #(
  parameter int unsigned CHANNELS    = 32,
  parameter int unsigned BITS        = 8,
  parameter int unsigned CLK_PER_BIT = 2,
  localparam int unsigned PHW = $clog2(CLK_PER_BIT),
  localparam int unsigned SLW = $clog2(BITS),
  localparam int unsigned CHW = $clog2(CHANNELS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CHW-1:0] nxt_chan,
  input  logic [SLW-1:0] nxt_slot,
  input  logic [PHW-1:0] nxt_phase,
  input  logic           rd_bit,
  output logic [SLW-1:0] rd_stream,
  output logic [CHW-1:0] rd_chan,
  output logic           ctl_q
);
  localparam logic [CHW-1:0] CH_LAST = CHW'(CHANNELS - 1);

  logic load_en;
  logic ctl_d;

  // address of the cell about to start, one channel ahead, stream = slot
  assign rd_stream = nxt_slot;
  assign rd_chan   = (nxt_chan == CH_LAST) ? '0 : nxt_chan + CHW'(1);
  assign load_en   = (nxt_phase == '0);

  always_comb begin
    ctl_d = ctl_q;
    if (load_en) ctl_d = rd_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= 1'b0;
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/tdm_frame_timing.sv
module tdm_frame_timing #(
  parameter int unsigned CHANNELS    = tdm_timing_pkg::DEF_CHANNELS,
  parameter int unsigned BITS        = tdm_timing_pkg::DEF_BITS,
  parameter int unsigned CLK_PER_BIT = tdm_timing_pkg::DEF_CLK_PER_BIT,
  localparam int unsigned PHW = $clog2(CLK_PER_BIT),
  localparam int unsigned SLW = $clog2(BITS),
  localparam int unsigned CHW = $clog2(CHANNELS),
  localparam int unsigned CW  = PHW + SLW + CHW,
  localparam int unsigned FRAME_CLKS = CHANNELS * BITS * CLK_PER_BIT
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fp_n,
  input  logic           ctl_rd_bit,
  output logic [CHW-1:0] chan_idx,
  output logic [SLW-1:0] bit_idx,
  output logic [PHW-1:0] bit_phase,
  output logic           frame_start,
  output logic [SLW-1:0] ctl_rd_stream,
  output logic [CHW-1:0] ctl_rd_chan,
  output logic           ctl_o
);
  logic [CW-1:0]  cnt_q, cnt_nxt;
  logic [SLW-1:0] cur_slot, nxt_slot;
  logic [CHW-1:0] nxt_chan;
  logic [PHW-1:0] nxt_phase;
  tdm_timing_pkg::cnt_event_e evt;

  tfg_frame_counter #(.FRAME_CLKS(FRAME_CLKS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .fp_n(fp_n),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .evt(evt)
  );

  tfg_pos_decode #(.CHANNELS(CHANNELS), .BITS(BITS), .CLK_PER_BIT(CLK_PER_BIT)) u_cur (
    .cnt(cnt_q), .chan(chan_idx), .slot(cur_slot), .phase(bit_phase)
  );

  tfg_pos_decode #(.CHANNELS(CHANNELS), .BITS(BITS), .CLK_PER_BIT(CLK_PER_BIT)) u_nxt (
    .cnt(cnt_nxt), .chan(nxt_chan), .slot(nxt_slot), .phase(nxt_phase)
  );

  tfg_ctl_gen #(.CHANNELS(CHANNELS), .BITS(BITS), .CLK_PER_BIT(CLK_PER_BIT)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .nxt_chan(nxt_chan), .nxt_slot(nxt_slot), .nxt_phase(nxt_phase),
    .rd_bit(ctl_rd_bit), .rd_stream(ctl_rd_stream), .rd_chan(ctl_rd_chan),
    .ctl_q(ctl_o)
  );

  // bits go out most significant first
  assign bit_idx     = SLW'(BITS - 1) - cur_slot;
  assign frame_start = (cnt_q == '0);
endmodule

// File: rtl/tdm_frame_timing_chk.sv
module tdm_frame_timing_chk #(
  parameter int unsigned CHW = 5,
  parameter int unsigned SLW = 3,
  parameter int unsigned PHW = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           fp_n,
  input logic [CHW-1:0] chan_idx,
  input logic [SLW-1:0] bit_idx,
  input logic [PHW-1:0] bit_phase,
  input logic           frame_start,
  input logic           ctl_o
);
  localparam logic [CHW-1:0] CH_LAST  = '1;
  localparam logic [SLW-1:0] BIT_TOP  = '1;
  localparam logic [PHW-1:0] PH_LAST  = '1;

  a_r2_phase_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_n && bit_phase == '0) |=> (bit_phase == PHW'(1)));

  a_r3_self_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (fp_n && chan_idx == CH_LAST && bit_idx == '0 && bit_phase == PH_LAST) |=> frame_start);

  a_r4_resync: assert property (@(posedge clk) disable iff (!rst_n)
    (!fp_n) |=> (chan_idx == '0 && bit_idx == BIT_TOP && bit_phase == '0));

  a_r5_start_pos: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (chan_idx == '0 && bit_idx == BIT_TOP && bit_phase == '0));

  a_r7_ctl_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_phase != '0) |-> $stable(ctl_o));
endmodule

bind tdm_frame_timing tdm_frame_timing_chk #(.CHW(CHW), .SLW(SLW), .PHW(PHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .chan_idx(chan_idx), .bit_idx(bit_idx),
  .bit_phase(bit_phase), .frame_start(frame_start), .ctl_o(ctl_o)
);

// File: tb/tb_tdm_frame_timing.sv
module tb_tdm_frame_timing;
  localparam int CLK_PERIOD = 10;
  localparam int FRAME = 512;

  logic       clk;
  logic       rst_n;
  logic       fp_n;
  logic       ctl_rd_bit;
  logic [4:0] chan_idx;
  logic [2:0] bit_idx;
  logic [0:0] bit_phase;
  logic       frame_start;
  logic [2:0] ctl_rd_stream;
  logic [4:0] ctl_rd_chan;
  logic       ctl_o;

  logic mem [8][32];

  int compared = 0;
  int mismatched = 0;
  int ref_cnt = 0;
  int ref_ctl = 0;
  int since_sync = 100;
  bit done = 0;

  tdm_frame_timing dut (
    .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .ctl_rd_bit(ctl_rd_bit),
    .chan_idx(chan_idx), .bit_idx(bit_idx), .bit_phase(bit_phase),
    .frame_start(frame_start), .ctl_rd_stream(ctl_rd_stream),
    .ctl_rd_chan(ctl_rd_chan), .ctl_o(ctl_o)
  );

  assign ctl_rd_bit = mem[ctl_rd_stream][ctl_rd_chan];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int f_chan(int c);  return (c / 2) / 8; endfunction
  function automatic int f_slot(int c);  return (c / 2) % 8; endfunction
  function automatic int f_bit(int c);   return 7 - f_slot(c); endfunction
  function automatic int f_phase(int c); return c % 2; endfunction
  function automatic int f_next(int c, logic fp); return fp ? (c + 1) % FRAME : 0; endfunction

  task automatic check(int act, int exp, string tag, string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d (ref count %0d)", tag, what, act, exp, ref_cnt);
    end
  endtask

  task automatic check_pos(string tag);
    check(int'(chan_idx), f_chan(ref_cnt), tag, "channel");
    check(int'(bit_idx), f_bit(ref_cnt), tag, "bit index");
    check(int'(bit_phase), f_phase(ref_cnt), tag, "phase");
    check(int'(frame_start), (ref_cnt == 0) ? 1 : 0, "R5", "frame_start");
  endtask

  // one clock: drive fp at a falling edge, check read address, advance reference, check outputs
  task automatic step(logic fpv);
    string t;
    int nx;
    fp_n = fpv;
    #1;
    nx = f_next(ref_cnt, fpv);
    check(int'(ctl_rd_stream), f_slot(nx), "R6", "read stream");
    check(int'(ctl_rd_chan), (f_chan(nx) + 1) % 32, "R6", "read channel");
    t = !fpv ? "R4" : ((ref_cnt == FRAME - 1) ? "R3" : "R2");
    @(posedge clk);
    ref_cnt = nx;
    since_sync = fpv ? since_sync + 1 : 0;
    if (f_phase(ref_cnt) == 0)
      ref_ctl = int'(mem[f_slot(ref_cnt)][(f_chan(ref_cnt) + 1) % 32]);
    @(negedge clk);
    check_pos(t);
    if (since_sync < 2)            check(int'(ctl_o), ref_ctl, "R9", "ctl after resync");
    else if (f_chan(ref_cnt) == 31) check(int'(ctl_o), ref_ctl, "R8", "ctl in channel 31");
    else                           check(int'(ctl_o), ref_ctl, "R7", "ctl bit");
  endtask

  task automatic flip_some();
    for (int k = 0; k < 4; k++) mem[$urandom_range(7)][$urandom_range(31)] = 1'($urandom);
  endtask

  initial begin
    void'($urandom(32'h1bad_5eed));
    rst_n = 1'b0;
    fp_n  = 1'b1;
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 32; c++) mem[s][c] = 1'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    check(int'(chan_idx), 0, "R1", "reset channel");
    check(int'(bit_idx), 7, "R1", "reset bit index");
    check(int'(bit_phase), 0, "R1", "reset phase");
    check(int'(frame_start), 1, "R1", "reset frame_start");
    check(int'(ctl_o), 0, "R1", "reset ctl");
    ref_cnt = 0; ref_ctl = 0;

    // free run over two and a half frames (R2, R3, R7, R8)
    for (int i = 0; i < 2 * FRAME + 256; i++) begin
      step(1'b1);
      if (i % 64 == 0) flip_some();
    end
    // directed: pulse on the last clock of a frame, then one clock later
    while (ref_cnt != FRAME - 1) step(1'b1);
    step(1'b0);
    step(1'b0);
    for (int i = 0; i < 40; i++) step(1'b1);
    // directed: pulse on phase 1 and on phase 0 mid-frame
    while (ref_cnt != 301) step(1'b1);
    step(1'b0);
    while (ref_cnt != 200) step(1'b1);
    step(1'b0);
    // random pulses at random points, with a changing control image
    for (int i = 0; i < 3000; i++) begin
      step(($urandom_range(99) < 2) ? 1'b0 : 1'b1);
      if ($urandom_range(15) == 0) flip_some();
    end
    // long run without pulses to cover the self wrap again
    for (int i = 0; i < FRAME + 100; i++) step(1'b1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule